// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Cycle Sequencer

This block performs one programmed-I/O register access at a time on a parallel ATA cable. A host presents a 5-bit register select code, a direction bit, a write word and a one-cycle start pulse. The sequencer then moves through four bus phases. It drives the chip selects and the address, waits out the setup time, and pulls the read or write strobe low. It keeps the strobe low for the minimum active time and for as long as the device holds IORDY low. It then releases the strobe and waits out the recovery time. At the end it returns the read word together with a one-cycle done pulse.

The phase lengths come from a per-mode table of nanosecond figures for PIO modes 0 to 4. These figures are converted to clock counts at elaboration. Data register accesses use the PIO mode of the currently selected device. Every other register uses the slower of the two attached devices' modes, so that either device can decode the access. A programmable limit bounds the IORDY wait. When the limit is hit, the cycle is forced to finish and a sticky error flag is raised.

States: `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_HOLDOFF` (strobe low, waiting for IORDY), `ST_RECOVER`, `ST_DONE`. Transitions:
- accept: IDLE to SETUP, on a start pulse while enabled.
- setup_over: SETUP to STROBE.
- ready_release: STROBE to RECOVER, when IORDY is high at the end of the active time.
- stretch: STROBE to HOLDOFF, when IORDY is low at the end of the active time.
- rdy_seen or timeout: HOLDOFF to RECOVER.
- recover_over: RECOVER to DONE.
- retire: DONE to IDLE.

Top module: `pio_cycle_engine`

## Requirements
- R1: While reset is held, and whenever the sequencer is idle, the bus outputs are in their quiet state: `ata_cs0_n`, `ata_cs1_n`, `ata_rd_n` and `ata_wr_n` are 1, `ata_dout_en` is 0 and `host_busy` is 0. Reset clears `host_tmo_err` to 0.
- R2: The select code is decoded as follows: bit 0 drives `ata_cs0_n`, bit 1 drives `ata_cs1_n` and bits 4:2 drive `ata_addr`. These values are held from the cycle after the start edge until recovery ends. Both strobes stay high for the whole setup phase.
- R3: Only one strobe moves per access: `ata_rd_n` for reads (`host_write`=0) and `ata_wr_n` for writes. For a write, `ata_dout_en` rises in the last setup cycle and stays high through the end of recovery.
- R4: A strobe stays low for exactly the active count if IORDY is high at the end of that count. Otherwise it stays low until the first clock edge at which IORDY is seen high.
- R5: The strobe is released, and then the recovery phase lasts (cycle count − active count − setup count) clocks, with a minimum of 1. It is followed by exactly one cycle of `host_done`, after which `host_busy` falls.
- R6: The timing mode is chosen per access. For select code 0x02 (data register), it is the mode of the device named by `cfg_dev_sel` (0 selects `cfg_mode_dev0`). For every other code, it is the smaller (slower) of the two mode fields. Mode values 5 to 7 act as mode 4.
- R7: Each mode has fixed setup/active/cycle figures in nanoseconds: mode 0 is 70/290/600, mode 1 is 50/290/383, mode 2 is 30/290/330, mode 3 is 30/80/180 and mode 4 is 25/70/120. Each figure becomes ceil(ns / `CLK_NS`) clocks, with a minimum of 1.
- R8: Read data is sampled from `ata_din` on the last strobe-low cycle. It is returned on `host_rdata` as all 16 bits for code 0x02, and as the zero-extended low byte for other codes. Writes to non-data codes drive the upper byte of `ata_dout` as 0. Writes leave `host_rdata` unchanged.
- R9: If IORDY is still low after `cfg_tmo_limit`+1 cycles in HOLDOFF, the strobe is released and the access finishes through recovery and done. `host_tmo_err` is then set and stays 1 until reset.
- R10: A start pulse is ignored while `cfg_enable` is 0 or while an access is in progress.
- R11: `cfg_wait_states` reports the selected device's clamped mode as a wait-state count: 3 for mode 0, 2 for modes 1 and 2, and 1 for modes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows new accesses |
| cfg_mode_dev0 | input | 3 | PIO mode of device 0 |
| cfg_mode_dev1 | input | 3 | PIO mode of device 1 |
| cfg_dev_sel | input | 1 | Currently selected device |
| cfg_tmo_limit | input | TMO_W | IORDY wait limit in clocks, minus one |
| cfg_wait_states | output | 2 | Wait-state count for the selected device's mode |
| host_start | input | 1 | One-cycle access request |
| host_sel | input | 5 | Register select code (address, CS1n, CS0n) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wdata | input | DATA_W | Write word |
| host_rdata | output | DATA_W | Last read word |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Access in progress |
| host_tmo_err | output | 1 | Sticky IORDY timeout flag |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_addr | output | 3 | Device register address |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | DATA_W | Write data to the bus |
| ata_dout_en | output | 1 | Write data drive enable |
| ata_din | input | DATA_W | Read data from the bus |
| ata_iordy | input | 1 | Device ready |

## Verification
The bound checker watches, on every clock, these rules:
- The two strobes are never low together, and a write strobe always has data driven with it.
- Chip selects and address do not move mid-access, and the strobes are high in the first setup cycle.
- A strobe is only released with IORDY high unless the timeout fired, and the timeout flag never drops.
- A done pulse is followed by idle, an idle sequencer without an accepted start stays idle, and the wait-state output is never zero.

Exact phase lengths, mode selection between the two devices, the clamp of modes 5 to 7, byte masking of read and write data, and the timeout count are shown only by the bench. Its behavioural model predicts every output on every clock, and directed scenarios measure strobe-low and busy lengths.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
    localparam int CNT_W   = 16;
    localparam int MODES   = 5;
    localparam int SEL_W   = 5;
    localparam logic [SEL_W-1:0] SEL_DATA = 5'h02;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t setup;
        cnt_t active;
        cnt_t recov;
    } pio_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLDOFF,
        ST_RECOVER,
        ST_DONE
    } pio_state_t;

    function automatic logic [2:0] clamp_mode(input logic [2:0] m);
        return (m > 3'd4) ? 3'd4 : m;
    endfunction

    function automatic int unsigned setup_ns(input int unsigned m);
        case (m)
            0:       return 70;
            1:       return 50;
            2, 3:    return 30;
            default: return 25;
        endcase
    endfunction

    function automatic int unsigned active_ns(input int unsigned m);
        case (m)
            0, 1, 2: return 290;
            3:       return 80;
            default: return 70;
        endcase
    endfunction

    function automatic int unsigned cycle_ns(input int unsigned m);
        case (m)
            0:       return 600;
            1:       return 383;
            2:       return 330;
            3:       return 180;
            default: return 120;
        endcase
    endfunction

    function automatic int unsigned to_clk(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic pio_timing_t mode_timing(input int unsigned m, input int unsigned clk_ns);
        pio_timing_t t;
        int s, a, c, r;
        s = int'(to_clk(setup_ns(m), clk_ns));
        a = int'(to_clk(active_ns(m), clk_ns));
        c = int'(to_clk(cycle_ns(m), clk_ns));
        r = c - a - s;
        if (r < 1) r = 1;
        t.setup  = cnt_t'(s);
        t.active = cnt_t'(a);
        t.recov  = cnt_t'(r);
        return t;
    endfunction
endpackage

// File: rtl/pio_timing_sel.sv
`timescale 1ns/1ps
module pio_timing_sel
    import pio_pkg::*;
#(
    parameter int unsigned CLK_NS = 5
) (
    input  logic [2:0]       mode_dev0,
    input  logic [2:0]       mode_dev1,
    input  logic             dev_sel,
    input  logic [SEL_W-1:0] sel,
    output pio_timing_t      timing,
    output logic [1:0]       wait_states
);
    pio_timing_t tbl [MODES];
    logic [2:0] ma, mb, m_dev, m_slow, m_use;

    for (genvar g = 0; g < MODES; g++) begin : g_mode
        assign tbl[g] = mode_timing(g, CLK_NS);
    end

    assign ma     = clamp_mode(mode_dev0);
    assign mb     = clamp_mode(mode_dev1);
    assign m_dev  = dev_sel ? mb : ma;
    assign m_slow = (ma < mb) ? ma : mb;
    assign m_use  = (sel == SEL_DATA) ? m_dev : m_slow;
    assign timing = tbl[m_use];

    always_comb begin
        unique case (m_dev)
            3'd0:       wait_states = 2'd3;
            3'd1, 3'd2: wait_states = 2'd2;
            default:    wait_states = 2'd1;
        endcase
    end
endmodule

// File: rtl/pio_fsm.sv
`timescale 1ns/1ps
module pio_fsm
    import pio_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             iordy,
    input  pio_timing_t      timing,
    input  logic [TMO_W-1:0] tmo_limit,
    output pio_state_t       state,
    output logic             accept,
    output logic             strobe_release,
    output logic             tmo_hit,
    output logic             last_setup
);
    pio_state_t       state_d;
    cnt_t             cnt_q, cnt_d;
    cnt_t             act_q, act_d;
    cnt_t             rec_q, rec_d;
    logic [TMO_W-1:0] wait_q, wait_d;

    // next-state and counters
    always_comb begin
        state_d        = state;
        cnt_d          = cnt_q;
        act_d          = act_q;
        rec_d          = rec_q;
        wait_d         = wait_q;
        accept         = 1'b0;
        strobe_release = 1'b0;
        tmo_hit        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) begin
                    accept  = 1'b1;
                    act_d   = timing.active;
                    rec_d   = timing.recov;
                    cnt_d   = timing.setup - 1'b1;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = ST_STROBE;
                    cnt_d   = act_q - 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (iordy) begin
                    strobe_release = 1'b1;
                    state_d        = ST_RECOVER;
                    cnt_d          = rec_q - 1'b1;
                end else begin
                    state_d = ST_HOLDOFF;
                    wait_d  = '0;
                end
            end
            ST_HOLDOFF: begin
                if (iordy || (wait_q == tmo_limit)) begin
                    strobe_release = 1'b1;
                    tmo_hit        = !iordy;
                    state_d        = ST_RECOVER;
                    cnt_d          = rec_q - 1'b1;
                end else begin
                    wait_d = wait_q + 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt_q  <= '0;
            act_q  <= '0;
            rec_q  <= '0;
            wait_q <= '0;
        end else begin
            state  <= state_d;
            cnt_q  <= cnt_d;
            act_q  <= act_d;
            rec_q  <= rec_d;
            wait_q <= wait_d;
        end
    end

    assign last_setup = (state == ST_SETUP) && (cnt_q == '0);
endmodule

// File: rtl/pio_data_path.sv
`timescale 1ns/1ps
module pio_data_path
    import pio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              write_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              strobe_release,
    input  logic              tmo_hit,
    input  logic [DATA_W-1:0] din,
    output logic [SEL_W-1:0]  sel_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              err_q
);
    localparam int BYTE_W = 8;
    localparam int HI_W   = DATA_W - BYTE_W;

    logic is_data_in, is_data_q;

    assign is_data_in = (sel_in == SEL_DATA);
    assign is_data_q  = (sel_q == SEL_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '1;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                sel_q   <= sel_in;
                write_q <= write_in;
                wdata_q <= is_data_in ? wdata_in : {{HI_W{1'b0}}, wdata_in[BYTE_W-1:0]};
            end
            if (strobe_release && !write_q) begin
                rdata_q <= is_data_q ? din : {{HI_W{1'b0}}, din[BYTE_W-1:0]};
            end
            if (tmo_hit) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pio_cycle_engine.sv
`timescale 1ns/1ps
module pio_cycle_engine
    import pio_pkg::*;
#(
    parameter int unsigned CLK_NS = 5,
    parameter int          TMO_W  = 16,
    parameter int          DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [2:0]        cfg_mode_dev0,
    input  logic [2:0]        cfg_mode_dev1,
    input  logic              cfg_dev_sel,
    input  logic [TMO_W-1:0]  cfg_tmo_limit,
    output logic [1:0]        cfg_wait_states,
    input  logic              host_start,
    input  logic [4:0]        host_sel,
    input  logic              host_write,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              host_busy,
    output logic              host_tmo_err,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_addr,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_dout_en,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iordy
);
    pio_timing_t      timing;
    pio_state_t       state;
    logic             accept, strobe_release, tmo_hit, last_setup;
    logic [SEL_W-1:0] sel_q;
    logic             write_q;

    pio_timing_sel #(.CLK_NS(CLK_NS)) u_tsel (
        .mode_dev0   (cfg_mode_dev0),
        .mode_dev1   (cfg_mode_dev1),
        .dev_sel     (cfg_dev_sel),
        .sel         (host_sel),
        .timing      (timing),
        .wait_states (cfg_wait_states)
    );

    pio_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_ok       (host_start && cfg_enable),
        .iordy          (ata_iordy),
        .timing         (timing),
        .tmo_limit      (cfg_tmo_limit),
        .state          (state),
        .accept         (accept),
        .strobe_release (strobe_release),
        .tmo_hit        (tmo_hit),
        .last_setup     (last_setup)
    );

    pio_data_path #(.DATA_W(DATA_W)) u_dp (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (accept),
        .sel_in         (host_sel),
        .write_in       (host_write),
        .wdata_in       (host_wdata),
        .strobe_release (strobe_release),
        .tmo_hit        (tmo_hit),
        .din            (ata_din),
        .sel_q          (sel_q),
        .write_q        (write_q),
        .wdata_q        (ata_dout),
        .rdata_q        (host_rdata),
        .err_q          (host_tmo_err)
    );

    // bus and host outputs from state
    always_comb begin
        ata_cs0_n   = 1'b1;
        ata_cs1_n   = 1'b1;
        ata_addr    = '0;
        ata_rd_n    = 1'b1;
        ata_wr_n    = 1'b1;
        ata_dout_en = 1'b0;
        host_done   = 1'b0;
        host_busy   = 1'b1;
        unique case (state)
            ST_IDLE: host_busy = 1'b0;
            ST_SETUP: begin
                {ata_addr, ata_cs1_n, ata_cs0_n} = sel_q;
                ata_dout_en = write_q && last_setup;
            end
            ST_STROBE, ST_HOLDOFF: begin
                {ata_addr, ata_cs1_n, ata_cs0_n} = sel_q;
                ata_rd_n    = write_q;
                ata_wr_n    = !write_q;
                ata_dout_en = write_q;
            end
            ST_RECOVER: begin
                {ata_addr, ata_cs1_n, ata_cs0_n} = sel_q;
                ata_dout_en = write_q;
            end
            ST_DONE:  host_done = 1'b1;
            default:  host_busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pio_cycle_engine_chk.sv
`timescale 1ns/1ps
module pio_cycle_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic       host_start,
    input logic       host_busy,
    input logic       host_done,
    input logic       host_tmo_err,
    input logic [1:0] cfg_wait_states,
    input logic       ata_cs0_n,
    input logic       ata_cs1_n,
    input logic [2:0] ata_addr,
    input logic       ata_rd_n,
    input logic       ata_wr_n,
    input logic       ata_dout_en,
    input logic       ata_iordy
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    // R3
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_wr_n |-> ata_dout_en);

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && $past(host_busy) && !host_done && !$past(host_done))
        |-> $stable({ata_addr, ata_cs1_n, ata_cs0_n}));

    // R2
    setup_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_busy) |-> (ata_rd_n && ata_wr_n));

    // R4
    iordy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ata_rd_n && ata_wr_n) && !host_tmo_err) |-> $past(ata_iordy));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_busy);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_tmo_err |=> host_tmo_err);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy && !(host_start && cfg_enable)) |=> !host_busy);

    // R11
    ws_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wait_states != 2'd0);
endmodule

bind pio_cycle_engine pio_cycle_engine_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_enable      (cfg_enable),
    .host_start      (host_start),
    .host_busy       (host_busy),
    .host_done       (host_done),
    .host_tmo_err    (host_tmo_err),
    .cfg_wait_states (cfg_wait_states),
    .ata_cs0_n       (ata_cs0_n),
    .ata_cs1_n       (ata_cs1_n),
    .ata_addr        (ata_addr),
    .ata_rd_n        (ata_rd_n),
    .ata_wr_n        (ata_wr_n),
    .ata_dout_en     (ata_dout_en),
    .ata_iordy       (ata_iordy)
);

// File: tb/pio_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module pio_cycle_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [2:0]  cfg_mode_dev0 = 3'd0;
    logic [2:0]  cfg_mode_dev1 = 3'd0;
    logic        cfg_dev_sel = 1'b0;
    logic [15:0] cfg_tmo_limit = 16'd1000;
    logic [1:0]  cfg_wait_states;
    logic        host_start = 1'b0;
    logic [4:0]  host_sel = 5'h02;
    logic        host_write = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_done, host_busy, host_tmo_err;
    logic        ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n, ata_dout_en;
    logic [2:0]  ata_addr;
    logic [15:0] ata_dout;
    logic [15:0] ata_din = 16'hBEEF;
    logic        ata_iordy = 1'b1;

    always #2.5 clk = ~clk;

    pio_cycle_engine dut_i (.*);

    int checks = 0, fails = 0, cyc = 0;
    int low_cnt = 0, busy_cnt = 0, done_cnt = 0;
    logic [15:0] last_dout = '0;
    bit cmp_on = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: phase timing from the requirements
    int set_ns[5] = '{70, 50, 30, 30, 25};
    int act_ns[5] = '{290, 290, 290, 80, 70};
    int cyc_ns[5] = '{600, 383, 330, 180, 120};
    function automatic int ck(input int ns);
        int c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int clampm(input int m);
        return (m > 4) ? 4 : m;
    endfunction

    int ph = 0, cnt = 0, tw = 0, ta = 0, tr = 0;
    int m_sel = 0, m_wr = 0, m_wd = 0, m_rd = 0, m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; m_err = 0; m_rd = 0;
        end else begin
            case (ph)
                0: if (host_start && cfg_enable) begin
                    int ma, mb, md, mu, ts;
                    ma = clampm(cfg_mode_dev0); mb = clampm(cfg_mode_dev1);
                    md = cfg_dev_sel ? mb : ma;
                    mu = (host_sel == 5'h02) ? md : ((ma < mb) ? ma : mb);
                    ts = ck(set_ns[mu]); ta = ck(act_ns[mu]);
                    tr = ck(cyc_ns[mu]) - ta - ts; if (tr < 1) tr = 1;
                    m_sel = host_sel; m_wr = host_write;
                    m_wd = (host_sel == 5'h02) ? host_wdata : (host_wdata & 16'h00FF);
                    cnt = ts; ph = 1;
                end
                1: begin cnt--; if (cnt == 0) begin ph = 2; cnt = ta; end end
                2: begin
                    cnt--;
                    if (cnt == 0) begin
                        if (ata_iordy) begin
                            if (!m_wr) m_rd = (m_sel == 2) ? ata_din : (ata_din & 16'h00FF);
                            ph = 4; cnt = tr;
                        end else begin ph = 3; tw = 0; end
                    end
                end
                3: begin
                    if (ata_iordy || tw == cfg_tmo_limit) begin
                        if (!ata_iordy) m_err = 1;
                        if (!m_wr) m_rd = (m_sel == 2) ? ata_din : (ata_din & 16'h00FF);
                        ph = 4; cnt = tr;
                    end else tw++;
                end
                4: begin cnt--; if (cnt == 0) ph = 5; end
                default: ph = 0;
            endcase
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            bit drv, low, den;
            drv = (ph >= 1 && ph <= 4);
            low = (ph == 2 || ph == 3);
            den = m_wr && ((ph == 1 && cnt == 1) || (ph >= 2 && ph <= 4));
            check("R1/R5 busy", host_busy, ph != 0);
            check("R5 done", host_done, ph == 5);
            check("R2 cs0_n", ata_cs0_n, drv ? m_sel & 1 : 1);
            check("R2 cs1_n", ata_cs1_n, drv ? (m_sel >> 1) & 1 : 1);
            check("R2 addr", ata_addr, drv ? (m_sel >> 2) & 7 : 0);
            check("R3/R4 rd_n", ata_rd_n, !(low && !m_wr));
            check("R3/R4 wr_n", ata_wr_n, !(low && m_wr));
            check("R3 dout_en", ata_dout_en, den);
            if (den) check("R8 dout", ata_dout, m_wd);
            check("R8 rdata", host_rdata, m_rd);
            check("R9 tmo_err", host_tmo_err, m_err);
        end
        if (!(ata_rd_n && ata_wr_n)) low_cnt++;
        if (host_busy) busy_cnt++;
        if (host_done) done_cnt++;
        if (ata_dout_en) last_dout = ata_dout;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic run_cycle(input logic [4:0] sel, input logic wr,
                             input logic [15:0] wd, input int rel);
        @(posedge clk); #1;
        host_sel = sel; host_write = wr; host_wdata = wd; host_start = 1'b1;
        low_cnt = 0; busy_cnt = 0;
        @(posedge clk); #1 host_start = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (k == rel) ata_iordy = 1'b1;
            if (host_done) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset cs/strobes", {ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n}, 4'hF);
        check("R1 reset busy/dout_en/err", {host_busy, ata_dout_en, host_tmo_err}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R11 wait states
        cfg_mode_dev0 = 3'd0; #1 check("R11 ws mode0", cfg_wait_states, 3);
        cfg_mode_dev0 = 3'd2; #1 check("R11 ws mode2", cfg_wait_states, 2);
        cfg_mode_dev0 = 3'd3; #1 check("R11 ws mode3", cfg_wait_states, 1);
        cfg_mode_dev0 = 3'd6; #1 check("R11 ws mode6 clamped", cfg_wait_states, 1);

        // R6 R7 status read uses slower device (mode 0)
        cfg_mode_dev0 = 3'd4; cfg_mode_dev1 = 3'd0; cfg_dev_sel = 1'b0;
        run_cycle(5'h1E, 1'b0, 16'h0, -1);
        check("R6 status read strobe low", low_cnt, 58);
        check("R5 status read busy", busy_cnt, 121);
        check("R8 byte read", host_rdata, 16'h00EF);

        // R6 data read uses device 0 (mode 4)
        run_cycle(5'h02, 1'b0, 16'h0, -1);
        check("R6 data read strobe low", low_cnt, 14);
        check("R5 data read busy", busy_cnt, 25);
        check("R8 word read", host_rdata, 16'hBEEF);

        // R3 R8 feature write, slower of modes 2 and 3
        cfg_mode_dev0 = 3'd2; cfg_mode_dev1 = 3'd3;
        run_cycle(5'h06, 1'b1, 16'hABCD, -1);
        check("R3 write strobe low", low_cnt, 58);
        check("R5 write busy", busy_cnt, 67);
        check("R8 byte write data", last_dout, 16'h00CD);
        check("R8 rdata kept on write", host_rdata, 16'hBEEF);

        // R6 data write uses device 1 (mode 3)
        cfg_dev_sel = 1'b1;
        run_cycle(5'h02, 1'b1, 16'h1234, -1);
        check("R6 data write strobe low", low_cnt, 16);
        check("R5 data write busy", busy_cnt, 37);
        check("R8 word write data", last_dout, 16'h1234);

        // R6 mode 7 acts as mode 4
        cfg_mode_dev1 = 3'd7; ata_din = 16'h5A3C;
        run_cycle(5'h02, 1'b0, 16'h0, -1);
        check("R6 clamped mode busy", busy_cnt, 25);
        check("R8 word read 2", host_rdata, 16'h5A3C);

        // R4 IORDY stretch
        cfg_dev_sel = 1'b0; cfg_mode_dev0 = 3'd4; ata_iordy = 1'b0;
        run_cycle(5'h02, 1'b0, 16'h0, 30);
        check("R4 stretched strobe low", low_cnt, 26);
        check("R4 no error on stretch", host_tmo_err, 0);

        // R10 start ignored while disabled
        @(posedge clk); #1 cfg_enable = 1'b0; host_start = 1'b1;
        @(posedge clk); #1 host_start = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 disabled start ignored", host_busy, 0);
        cfg_enable = 1'b1;

        // R10 start ignored while busy
        done_cnt = 0;
        @(posedge clk); #1 host_sel = 5'h0A; host_write = 1'b0; host_start = 1'b1;
        @(posedge clk); #1 host_start = 1'b0;
        repeat (8) @(posedge clk);
        #1 host_start = 1'b1;
        @(posedge clk); #1 host_start = 1'b0;
        for (int k = 0; k < 2000 && host_busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R10 busy start ignored", done_cnt, 1);

        // R9 timeout
        cfg_tmo_limit = 16'd3; ata_iordy = 1'b0;
        run_cycle(5'h02, 1'b0, 16'h0, -1);
        check("R9 timeout strobe low", low_cnt, 18);
        check("R9 timeout flag", host_tmo_err, 1);
        ata_iordy = 1'b1;
        run_cycle(5'h02, 1'b0, 16'h0, -1);
        check("R9 flag sticky", host_tmo_err, 1);

        // R1 reset clears the flag
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears err", host_tmo_err, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule